// File: doc/BRIEF.md
# Byte-Lane Masked Synchronous Block RAM

A single-port synchronous memory whose address, write data, write strobe and lane-select inputs are first captured in an input register stage. The captured operation is applied to the storage array on the following enabled edge. Each word is split into lanes, and a write touches only the lanes whose select bit is set. The other lanes keep their stored contents. The word width is a parameter. At 16 and 32 bits the lanes are 8 bits wide. At 18 and 36 bits the lanes are 9 bits wide, which leaves one spare bit per byte for an external parity scheme.

Lane masking applies only to the four supported widths. Any other width, including words narrower than two bytes, ignores the lane selects and writes whole words. A clock enable freezes the entire pipeline. The read port always returns the full stored word. When a read and a write hit the same address, the read returns the contents as they were before the write.

Top module: `bram_be`

## Requirements
- R1: When the captured write strobe is 0, no part of the memory changes.
- R2: In 36-bit mode, select bit i guards bits 9*i+8 down to 9*i. In 32-bit mode it guards bits 8*i+7 down to 8*i. Any mix of select bits is legal.
- R3: In 16-bit mode, select bit 0 guards bits 7:0 and select bit 1 guards bits 15:8. In 18-bit mode the lanes are bits 8:0 and 17:9.
- R4: With all select bits 0, a write leaves the word unchanged. With all select bits 1, the write strobe alone decides, and the whole word is written.
- R5: For any width other than 16, 18, 32 or 36, the single select bit is ignored, and a write stores the whole word.
- R6: Inputs are captured on an enabled edge. On the next enabled edge the write is performed, and `rdata` takes the old contents of the captured address (read-before-write).
- R7: A synchronous active-low reset clears `rdata` to 0 and cancels a captured write that has not yet been applied. The captured address, data and lane-select registers have no clear.
- R8: While `ce` is 0, the input registers, the memory and `rdata` all hold. A captured operation completes on the next edge with `ce` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Clock enable for all stages |
| we | input | 1 | Write strobe |
| be | input | LANES | Lane select, bit i for lane i (4 at the default width) |
| addr | input | ADDR_W | Word address, ADDR_W = ceil(log2(DEPTH)) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |

## Verification
The bench drives three instances (36, 16 and 8 bits wide) with the same stimulus.

It tries select patterns that alternate lanes, and checks that a lane slipped by one bit (a design that used 8-bit lanes in 36-bit mode) corrupts a neighbour. It checks that an all-zero select writes nothing. It checks that the narrow instance writes even when its select bit is 0; a design that masked there would leave old data.

It also checks that a read returns pre-write data at the written address, that a reset between capture and apply cancels the write, and that a held operation survives a stretch with `ce` at 0 without taking up the inputs that changed meanwhile.

// File: rtl/bram_be_pkg.sv
package bram_be_pkg;

    typedef enum logic [1:0] {
        MODE_WHOLE = 2'd0,
        MODE_OCTET = 2'd1,
        MODE_NONET = 2'd2
    } lane_mode_e;

    function automatic lane_mode_e lane_mode(input int dw);
        if (dw == 16 || dw == 32) return MODE_OCTET;
        if (dw == 18 || dw == 36) return MODE_NONET;
        return MODE_WHOLE;
    endfunction

    function automatic int lane_bits(input int dw);
        case (lane_mode(dw))
            MODE_OCTET: return 8;
            MODE_NONET: return 9;
            default:    return dw;
        endcase
    endfunction

    function automatic int lane_total(input int dw);
        return dw / lane_bits(dw);
    endfunction

endpackage

// File: rtl/bram_in_stage.sv
module bram_in_stage #(
    parameter int DATA_W = 36,
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic [LANES-1:0]  be,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              we_q,
    output logic [LANES-1:0]  be_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    // Only the write strobe is cleared; the lane selects, address and data have no clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b0;
        end else if (ce) begin
            we_q <= we;
        end
    end

    always_ff @(posedge clk) begin
        if (ce) begin
            be_q    <= be;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

endmodule

// File: rtl/bram_lane_mask.sv
module bram_lane_mask
    import bram_be_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic             we_q,
    input  logic [LANES-1:0] be_q,
    output logic [LANES-1:0] lane_wr
);

    localparam lane_mode_e MODE = lane_mode(DATA_W);

    generate
        if (MODE == MODE_WHOLE) begin : g_whole
            // Widths without lane support ignore the select input.
            logic unused_be;
            assign unused_be = ^be_q;
            assign lane_wr   = {LANES{we_q}};
        end else begin : g_masked
            assign lane_wr = be_q & {LANES{we_q}};
        end
    endgenerate

endmodule

// File: rtl/bram_store.sv
module bram_store #(
    parameter int DATA_W = 36,
    parameter int LANES  = 4,
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata
);

    localparam int LW = DATA_W / LANES;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ce && rst_n) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_wr[l]) begin
                    mem[addr_q][l*LW +: LW] <= wdata_q[l*LW +: LW];
                end
            end
        end
    end

    // Non-blocking read of the same word gives the pre-write contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (ce) begin
            rdata <= mem[addr_q];
        end
    end

endmodule

// File: rtl/bram_be.sv
module bram_be
    import bram_be_pkg::*;
#(
    parameter  int DATA_W = 36,
    parameter  int DEPTH  = 256,
    localparam int LANES  = lane_total(DATA_W),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic [LANES-1:0]  be,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic              we_q;
    logic [LANES-1:0]  be_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  lane_wr;

    bram_in_stage #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_in (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .be(be), .addr(addr),
        .wdata(wdata), .we_q(we_q), .be_q(be_q), .addr_q(addr_q), .wdata_q(wdata_q)
    );

    bram_lane_mask #(.DATA_W(DATA_W), .LANES(LANES)) u_mask (
        .we_q(we_q), .be_q(be_q), .lane_wr(lane_wr)
    );

    bram_store #(.DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .ce(ce), .lane_wr(lane_wr), .addr_q(addr_q),
        .wdata_q(wdata_q), .rdata(rdata)
    );

endmodule

// File: rtl/bram_be_chk.sv
module bram_be_chk #(
    parameter int DATA_W = 36,
    parameter int LANES  = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              we_q,
    input logic [LANES-1:0]  be_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic [DATA_W-1:0] wdata_q,
    input logic [LANES-1:0]  lane_wr,
    input logic [DATA_W-1:0] rdata
);

    localparam bit MASKED = (DATA_W == 16 || DATA_W == 18 || DATA_W == 32 || DATA_W == 36);

    a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(addr_q) && $stable(wdata_q) && $stable(be_q) && $stable(we_q)));

    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(rdata));

    a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rdata == '0 && !we_q));

    a_r1_no_strobe_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !we_q |-> (lane_wr == '0));

    generate
        if (!MASKED) begin : g_narrow
            a_r5_whole_word: assert property (@(posedge clk) disable iff (!rst_n)
                we_q |-> (&lane_wr));
        end
    endgenerate

endmodule

bind bram_be bram_be_chk #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we_q(we_q), .be_q(be_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .lane_wr(lane_wr), .rdata(rdata)
);

// File: tb/bram_be_tb.sv
`timescale 1ns/1ps
module bram_be_tb;

    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce;
    logic          we;
    logic [3:0]    be;
    logic [AW-1:0] addr;
    logic [35:0]   wdata;
    logic [35:0]   rd36;
    logic [15:0]   rd16;
    logic [7:0]    rd8;

    int checks = 0;
    int fails  = 0;

    logic [35:0] m36 [DEPTH];
    logic [35:0] m16 [DEPTH];
    logic [35:0] m8  [DEPTH];

    always #2 clk = ~clk;

    bram_be #(.DATA_W(36), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .be(be), .addr(addr),
        .wdata(wdata), .rdata(rd36));

    bram_be #(.DATA_W(16), .DEPTH(DEPTH)) u_dut16 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .be(be[1:0]), .addr(addr),
        .wdata(wdata[15:0]), .rdata(rd16));

    bram_be #(.DATA_W(8), .DEPTH(DEPTH)) u_dut8 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .be(be[0]), .addr(addr),
        .wdata(wdata[7:0]), .rdata(rd8));

    // Expected new word: 36-bit uses 9-bit lanes (R2), 16-bit uses 8-bit lanes (R3), 8-bit ignores selects (R5).
    function automatic logic [35:0] merge(input int w, input logic [35:0] old,
                                          input logic [35:0] nw, input logic [3:0] b);
        logic [35:0] r = old;
        if (w == 8) begin
            r = {28'b0, nw[7:0]};
        end else if (w == 16) begin
            if (b[0]) r[7:0]  = nw[7:0];
            if (b[1]) r[15:8] = nw[15:8];
            r[35:16] = '0;
        end else begin
            for (int i = 0; i < 4; i++) if (b[i]) r[9*i +: 9] = nw[9*i +: 9];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [35:0] e36,
                           input logic [35:0] e16, input logic [35:0] e8);
        chk({tag, " w36"}, rd36, e36);
        chk({tag, " w16"}, {20'b0, rd16}, e16);
        chk({tag, " w8"},  {28'b0, rd8},  e8);
    endtask

    // One operation: capture, apply, then check old-data read (R6) and update models.
    task automatic op(input string tag, input logic [AW-1:0] a, input logic [35:0] d,
                      input logic w, input logic [3:0] b);
        @(negedge clk);
        ce = 1'b1; addr = a; wdata = d; we = w; be = b;
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        chk_all({tag, " R6 old-data"}, m36[a], m16[a], m8[a]);
        if (w) begin
            m36[a] = merge(36, m36[a], d, b);
            m16[a] = merge(16, m16[a], d, b);
            m8[a]  = merge(8,  m8[a],  d, b);
        end
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a);
        @(negedge clk);
        ce = 1'b1; addr = a; we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_all(tag, m36[a], m16[a], m8[a]);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; ce = 1'b1; we = 1'b0; be = 4'hf; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_all("R7 reset rdata", 36'h0, 36'h0, 36'h0);
    endtask

    task automatic t_fill;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            ce = 1'b1; addr = AW'(a); wdata = {4'h9, 32'h1234_5670 + 32'(a * 32'h0101_0101)};
            we = 1'b1; be = 4'hf;
            @(negedge clk);
            we = 1'b0;
            @(negedge clk);
            m36[a] = wdata;
            m16[a] = {20'b0, wdata[15:0]};
            m8[a]  = {28'b0, wdata[7:0]};
        end
        rd("R4 full write addr0", 4'd0);
        rd("R4 full write addr15", 4'd15);
    endtask

    task automatic t_lanes;
        op("R2 be=0101", 4'd2, 36'hA_BCDE_F012, 1'b1, 4'b0101);
        rd("R2 R3 be=0101 readback", 4'd2);
        op("R2 be=1010", 4'd3, 36'h5_5AA5_5AA5, 1'b1, 4'b1010);
        rd("R2 R3 be=1010 readback", 4'd3);
        op("R2 be=1000", 4'd4, 36'hF_FFFF_FFFF, 1'b1, 4'b1000);
        rd("R2 be=1000 readback", 4'd4);
        op("R4 be=0000", 4'd5, 36'h0_0000_0000, 1'b1, 4'b0000);
        rd("R4 R5 be=0000 readback", 4'd5);
        op("R3 be=0010", 4'd6, 36'h3_C3C3_C3C3, 1'b1, 4'b0010);
        rd("R3 R5 be=0010 readback", 4'd6);
    endtask

    task automatic t_no_we;
        op("R1 we=0", 4'd7, 36'h0_DEAD_BEEF, 1'b0, 4'hf);
        rd("R1 we=0 readback", 4'd7);
    endtask

    task automatic t_same_addr;
        op("R6 first", 4'd8, 36'h1_1111_1111, 1'b1, 4'hf);
        op("R6 second", 4'd8, 36'h2_2222_2222, 1'b1, 4'hf);
        rd("R6 final", 4'd8);
    endtask

    task automatic t_reset_cancel;
        logic [35:0] d;
        d = 36'h7_7777_7777;
        @(negedge clk);
        ce = 1'b1; addr = 4'd9; wdata = d; we = 1'b1; be = 4'hf;
        @(negedge clk);
        rst_n = 1'b0; we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_all("R7 reset mid-op rdata", 36'h0, 36'h0, 36'h0);
        rd("R7 cancelled write", 4'd9);
    endtask

    task automatic t_ce_hold;
        logic [35:0] h36, h16, h8;
        @(negedge clk);
        ce = 1'b1; addr = 4'd10; wdata = 36'hC_0FFE_E123; we = 1'b1; be = 4'hf;
        @(negedge clk);
        h36 = rd36; h16 = {20'b0, rd16}; h8 = {28'b0, rd8};
        ce = 1'b0; addr = 4'd11; wdata = 36'h0_BAD0_BAD0; we = 1'b1; be = 4'hf;
        repeat (3) @(negedge clk);
        chk_all("R8 rdata held", h36, h16, h8);
        ce = 1'b1; addr = 4'd10; we = 1'b0;
        @(negedge clk);
        chk_all("R8 held op old-data", m36[10], m16[10], m8[10]);
        m36[10] = 36'hC_0FFE_E123;
        m16[10] = 36'h0_0000_E123;
        m8[10]  = 36'h0_0000_0023;
        rd("R8 held write applied", 4'd10);
        rd("R8 ignored inputs", 4'd11);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_lanes();
        t_no_we();
        t_same_addr();
        t_reset_cancel();
        t_ce_hold();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule